// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Tag Capture

This block holds a small set of waiting operations for one class of execution unit, three entries by default. Each issued operation brings an operation code and two sources. A source is either a value that is already known, or the tag of the station that will later produce it. Source tag zero means the value travels with the issue.

The pool watches a shared result bus that carries 64 data bits and a 4-bit producer tag. Any waiting source whose tag matches the bus copies the data in and becomes ready. Every entry whose two sources are ready is a candidate, and each cycle the pool sends at most one of them to the execution unit. An entry stays allocated until the result bus shows its own tag, and it is released on the next clock edge. When every entry is allocated, the pool lowers its issue-ready output and drops any issue offered in that cycle. The execution unit is outside the block. In the bench, a pipelined stub with a fixed latency stands in for it.

Top module: `rsv_pool`

## Requirements
- R1: After reset no entry is allocated: `iss_ready` is 1 and `disp_valid` is 0.
- R2: Entry k has the fixed result tag BASE_TAG+k (1, 2 and 3 by default), and `disp_tag` shows this tag. An accepted issue goes into the free entry with the lowest index.
- R3: A source issued with tag 0 takes its issue value as its operand. An entry whose two sources are both ready at issue is offered on `disp_valid` in the cycle after the issue edge, and `disp_opa`/`disp_opb`/`disp_op` carry its operands and opcode.
- R4: A source issued with a nonzero tag holds its entry back from dispatch. The entry waits until the result bus is valid with an equal tag, then takes the bus data as that operand.
- R5: A single broadcast fills every waiting source with an equal tag, in all entries and in both sources of one entry, on the same edge.
- R6: If a source's producer tag appears on the result bus in the issue cycle itself, the issued entry takes the bus data and is ready at once.
- R7: At most one entry is dispatched per cycle, the ready entry with the lowest index goes first, and a dispatched entry is never offered again.
- R8: A dispatched entry stays allocated until the result bus is valid with its own tag. It is freed on that edge and can be reused.
- R9: While all entries are allocated, `iss_ready` is 0 and an offered issue leaves no trace: nothing is allocated and nothing is later dispatched.
- R10: A broadcast whose tag matches no waiting source changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | At least one entry is free |
| iss_op | input | 4 | Operation code of the issued operation |
| iss_tag_a | input | 4 | Producer tag of source A, 0 when the value is given |
| iss_val_a | input | 64 | Value of source A |
| iss_tag_b | input | 4 | Producer tag of source B, 0 when the value is given |
| iss_val_b | input | 64 | Value of source B |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | 4 | Tag of the station producing the result |
| cdb_data | input | 64 | Result data |
| disp_valid | output | 1 | An entry is sent to the execution unit |
| disp_op | output | 4 | Opcode of the dispatched entry |
| disp_opa | output | 64 | Operand A of the dispatched entry |
| disp_opb | output | 64 | Operand B of the dispatched entry |
| disp_tag | output | 4 | Tag under which the unit must broadcast the result |

## Verification
The bound checker watches these rules on every cycle: dispatch grants are one-hot and go only to ready entries, the lowest ready index wins, and a granted entry is not offered again. It also checks that an entry is freed exactly when its own tag is broadcast after dispatch, and that a stalled issue never increases the number of allocated entries. Operand values can only be shown by the bench scenarios: that captured data reaches the execution unit, that a bus result in the issue cycle is not missed, that one broadcast wakes two entries, that an unrelated tag is ignored, and that an issue dropped while the pool is full never shows up later.

// File: rtl/rsv_pkg.sv
`timescale 1ns/1ps
package rsv_pkg;
    localparam int DATA_W = 64;
    localparam int TAG_W  = 4;
    localparam int OP_W   = 4;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [OP_W-1:0]   op_t;

    // one station: a zero tag means the matching value field is valid
    typedef struct packed {
        logic  busy;
        logic  sent;
        op_t   op;
        tag_t  tag_a;
        tag_t  tag_b;
        data_t val_a;
        data_t val_b;
    } ent_t;
endpackage

// File: rtl/rsv_pick.sv
`timescale 1ns/1ps
// lowest-index-first one-hot picker
module rsv_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/rsv_entry.sv
`timescale 1ns/1ps
module rsv_entry
    import rsv_pkg::*;
#(
    parameter tag_t MY_TAG = tag_t'(1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  op_t   iss_op,
    input  tag_t  iss_tag_a,
    input  data_t iss_val_a,
    input  tag_t  iss_tag_b,
    input  data_t iss_val_b,
    input  logic  cdb_valid,
    input  tag_t  cdb_tag,
    input  data_t cdb_data,
    input  logic  grant,
    output logic  busy,
    output logic  sent,
    output logic  ready,
    output op_t   op,
    output data_t val_a,
    output data_t val_b
);
    ent_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (ent_q.busy) begin
            // snoop the result bus for each waiting source
            if (ent_q.tag_a != '0 && cdb_valid && cdb_tag == ent_q.tag_a) begin
                ent_d.val_a = cdb_data;
                ent_d.tag_a = '0;
            end
            if (ent_q.tag_b != '0 && cdb_valid && cdb_tag == ent_q.tag_b) begin
                ent_d.val_b = cdb_data;
                ent_d.tag_b = '0;
            end
            if (grant) begin
                ent_d.sent = 1'b1;
            end
            if (ent_q.sent && cdb_valid && cdb_tag == MY_TAG) begin
                ent_d.busy = 1'b0;
                ent_d.sent = 1'b0;
            end
        end else if (load) begin
            ent_d.busy = 1'b1;
            ent_d.sent = 1'b0;
            ent_d.op   = iss_op;
            // a producer broadcasting in the issue cycle is caught here
            if (iss_tag_a != '0 && cdb_valid && cdb_tag == iss_tag_a) begin
                ent_d.val_a = cdb_data;
                ent_d.tag_a = '0;
            end else begin
                ent_d.val_a = iss_val_a;
                ent_d.tag_a = iss_tag_a;
            end
            if (iss_tag_b != '0 && cdb_valid && cdb_tag == iss_tag_b) begin
                ent_d.val_b = cdb_data;
                ent_d.tag_b = '0;
            end else begin
                ent_d.val_b = iss_val_b;
                ent_d.tag_b = iss_tag_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign busy  = ent_q.busy;
    assign sent  = ent_q.sent;
    assign ready = ent_q.busy && !ent_q.sent && ent_q.tag_a == '0 && ent_q.tag_b == '0;
    assign op    = ent_q.op;
    assign val_a = ent_q.val_a;
    assign val_b = ent_q.val_b;
endmodule

// File: rtl/rsv_pool.sv
`timescale 1ns/1ps
module rsv_pool
    import rsv_pkg::*;
#(
    parameter int NUM_ENT  = 3,
    parameter int BASE_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_tag_a,
    input  logic [DATA_W-1:0] iss_val_a,
    input  logic [TAG_W-1:0]  iss_tag_b,
    input  logic [DATA_W-1:0] iss_val_b,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_opa,
    output logic [DATA_W-1:0] disp_opb,
    output logic [TAG_W-1:0]  disp_tag
);
    logic [NUM_ENT-1:0] ent_busy;
    logic [NUM_ENT-1:0] ent_sent;
    logic [NUM_ENT-1:0] ent_rdy;
    logic [NUM_ENT-1:0] alloc_gnt;
    logic [NUM_ENT-1:0] disp_gnt;
    op_t                ent_op  [NUM_ENT];
    data_t              ent_va  [NUM_ENT];
    data_t              ent_vb  [NUM_ENT];

    rsv_pick #(.N(NUM_ENT)) u_alloc (
        .req (~ent_busy),
        .gnt (alloc_gnt),
        .any (iss_ready)
    );

    rsv_pick #(.N(NUM_ENT)) u_disp (
        .req (ent_rdy),
        .gnt (disp_gnt),
        .any (disp_valid)
    );

    for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
        rsv_entry #(.MY_TAG(tag_t'(BASE_TAG + k))) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (iss_valid && alloc_gnt[k]),
            .iss_op    (iss_op),
            .iss_tag_a (iss_tag_a),
            .iss_val_a (iss_val_a),
            .iss_tag_b (iss_tag_b),
            .iss_val_b (iss_val_b),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_data  (cdb_data),
            .grant     (disp_gnt[k]),
            .busy      (ent_busy[k]),
            .sent      (ent_sent[k]),
            .ready     (ent_rdy[k]),
            .op        (ent_op[k]),
            .val_a     (ent_va[k]),
            .val_b     (ent_vb[k])
        );
    end

    // one-hot grant, so an OR mux selects the dispatched entry
    always_comb begin
        disp_op  = '0;
        disp_opa = '0;
        disp_opb = '0;
        disp_tag = '0;
        for (int k = 0; k < NUM_ENT; k++) begin
            if (disp_gnt[k]) begin
                disp_op  = disp_op  | ent_op[k];
                disp_opa = disp_opa | ent_va[k];
                disp_opb = disp_opb | ent_vb[k];
                disp_tag = disp_tag | tag_t'(BASE_TAG + k);
            end
        end
    end
endmodule

// File: rtl/rsv_pool_chk.sv
`timescale 1ns/1ps
module rsv_pool_chk
    import rsv_pkg::*;
#(
    parameter int NUM_ENT  = 3,
    parameter int BASE_TAG = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               iss_valid,
    input logic               iss_ready,
    input logic [NUM_ENT-1:0] busy_vec,
    input logic [NUM_ENT-1:0] sent_vec,
    input logic [NUM_ENT-1:0] rdy_vec,
    input logic [NUM_ENT-1:0] gnt_vec,
    input logic               disp_valid,
    input logic [TAG_W-1:0]   disp_tag,
    input logic               cdb_valid,
    input logic [TAG_W-1:0]   cdb_tag
);
    // R7: one grant per dispatch, only to a ready entry
    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ($countones(gnt_vec) == 1 && (gnt_vec & ~rdy_vec) == '0));

    // R7: no lower-index ready entry is passed over
    assert_lowest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (((gnt_vec - 1'b1) & rdy_vec) == '0));

    // R9: a stalled issue does not add an allocated entry
    assert_stall_no_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> ($countones(busy_vec) <= $past($countones(busy_vec))));

    // R2: dispatch tag belongs to this pool
    assert_tag_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_tag >= TAG_W'(BASE_TAG) && disp_tag < TAG_W'(BASE_TAG + NUM_ENT)));

    for (genvar k = 0; k < NUM_ENT; k++) begin : g_chk
        localparam logic [TAG_W-1:0] KTAG = TAG_W'(BASE_TAG + k);

        // R8: own broadcast after dispatch frees the entry
        assert_free_on_own_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_vec[k] && sent_vec[k] && cdb_valid && cdb_tag == KTAG) |=> !busy_vec[k]);

        // R8: without that broadcast the entry stays allocated
        assert_hold_until_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_vec[k] && !(sent_vec[k] && cdb_valid && cdb_tag == KTAG)) |=> busy_vec[k]);

        // R7: a granted entry is never offered again
        assert_no_redispatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vec[k] |=> !rdy_vec[k]);
    end
endmodule

bind rsv_pool rsv_pool_chk #(.NUM_ENT(NUM_ENT), .BASE_TAG(BASE_TAG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .busy_vec   (ent_busy),
    .sent_vec   (ent_sent),
    .rdy_vec    (ent_rdy),
    .gnt_vec    (disp_gnt),
    .disp_valid (disp_valid),
    .disp_tag   (disp_tag),
    .cdb_valid  (cdb_valid),
    .cdb_tag    (cdb_tag)
);

// File: tb/rsv_pool_test.sv
`timescale 1ns/1ps
module rsv_pool_test;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic        iss_ready;
    logic [3:0]  iss_op = '0;
    logic [3:0]  iss_tag_a = '0;
    logic [63:0] iss_val_a = '0;
    logic [3:0]  iss_tag_b = '0;
    logic [63:0] iss_val_b = '0;
    logic        cdb_valid;
    logic [3:0]  cdb_tag;
    logic [63:0] cdb_data;
    logic        disp_valid;
    logic [3:0]  disp_op;
    logic [63:0] disp_opa;
    logic [63:0] disp_opb;
    logic [3:0]  disp_tag;

    logic        ext_v = 1'b0;
    logic [3:0]  ext_tag = '0;
    logic [63:0] ext_data = '0;

    logic        st_v   [LAT];
    logic [3:0]  st_tag [LAT];
    logic [63:0] st_res [LAT];

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rsv_pool uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
        .iss_tag_a(iss_tag_a), .iss_val_a(iss_val_a),
        .iss_tag_b(iss_tag_b), .iss_val_b(iss_val_b),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_opa(disp_opa),
        .disp_opb(disp_opb), .disp_tag(disp_tag)
    );

    function automatic logic [63:0] unit_fn(input logic [3:0] op, input logic [63:0] a,
                                            input logic [63:0] b);
        case (op)
            4'd0:    return a + b;
            4'd1:    return a - b;
            4'd2:    return a & b;
            default: return a ^ b;
        endcase
    endfunction

    // fixed-latency stand-in for the execution unit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                st_v[i] <= 1'b0; st_tag[i] <= '0; st_res[i] <= '0;
            end
        end else begin
            st_v[0]   <= disp_valid;
            st_tag[0] <= disp_tag;
            st_res[0] <= unit_fn(disp_op, disp_opa, disp_opb);
            for (int i = 1; i < LAT; i++) begin
                st_v[i] <= st_v[i-1]; st_tag[i] <= st_tag[i-1]; st_res[i] <= st_res[i-1];
            end
        end
    end

    assign cdb_valid = st_v[LAT-1] | ext_v;
    assign cdb_tag   = st_v[LAT-1] ? st_tag[LAT-1] : ext_tag;
    assign cdb_data  = st_v[LAT-1] ? st_res[LAT-1] : ext_data;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  ta;
        logic [63:0] va;
        logic [3:0]  tb;
        logic [63:0] vb;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd0, 4'd0,  64'd10,                4'd0,  64'd32},
        '{4'd1, 4'd0,  64'd100,               4'd0,  64'd1},
        '{4'd2, 4'd8,  64'hF0F0,              4'd0,  64'hFF00},
        '{4'd3, 4'd0,  64'hAAAA,              4'd9,  64'h5555},
        '{4'd0, 4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 4'd11, 64'd1},
        '{4'd1, 4'd14, 64'd5,                 4'd15, 64'd7}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [3:0] ta, input logic [63:0] va,
                         input logic [3:0] tb, input logic [63:0] vb);
        iss_valid = 1'b1; iss_op = op;
        iss_tag_a = ta; iss_val_a = va; iss_tag_b = tb; iss_val_b = vb;
        step();
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input logic [3:0] tag, input logic [63:0] data);
        ext_v = 1'b1; ext_tag = tag; ext_data = data;
        step();
        ext_v = 1'b0;
    endtask

    task automatic wait_result(input logic [3:0] tag, input logic [63:0] exp, input string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (cdb_valid && cdb_tag == tag) seen = 1'b1;
            else step();
        end
        check(seen, req, "result broadcast seen", 64'(seen), 64'd1);
        if (seen) check(cdb_data == exp, req, "result data", cdb_data, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        check(iss_ready == 1'b1, "R1", "iss_ready after reset", 64'(iss_ready), 64'd1);
        check(disp_valid == 1'b0, "R1", "disp_valid after reset", 64'(disp_valid), 64'd0);

        // vector table: R3 ready sources, R4 tag-captured sources, R2 tag of entry 0
        foreach (VECS[i]) begin
            vec_t v;
            v = VECS[i];
            issue(v.op, v.ta, (v.ta != 0) ? 64'hDEAD : v.va, v.tb, (v.tb != 0) ? 64'hBEEF : v.vb);
            check(disp_valid == (v.ta == 0 && v.tb == 0), (v.ta == 0 && v.tb == 0) ? "R3" : "R4",
                  "dispatch only when both sources ready", 64'(disp_valid),
                  64'(v.ta == 0 && v.tb == 0));
            if (v.ta != 0) bcast(v.ta, v.va);
            if (v.tb != 0) bcast(v.tb, v.vb);
            check(disp_valid && disp_tag == 4'd1, "R2", "dispatch tag of entry 0",
                  64'(disp_tag), 64'd1);
            check(disp_opa == v.va && disp_opb == v.vb && disp_op == v.op, "R3",
                  "dispatched operands", disp_opa ^ disp_opb, v.va ^ v.vb);
            wait_result(4'd1, unit_fn(v.op, v.va, v.vb), "R4");
            step();
        end

        // R6: producer broadcasts in the issue cycle
        ext_v = 1'b1; ext_tag = 4'd9; ext_data = 64'h1234_5678;
        issue(4'd0, 4'd9, 64'h0, 4'd0, 64'd6);
        ext_v = 1'b0;
        check(disp_valid == 1'b1, "R6", "same-cycle capture makes entry ready",
              64'(disp_valid), 64'd1);
        check(disp_opa == 64'h1234_5678, "R6", "same-cycle captured operand",
              disp_opa, 64'h1234_5678);
        wait_result(4'd1, 64'h1234_567E, "R6");
        step();

        // R10, R5, R7: unrelated tag ignored, one broadcast wakes two entries
        issue(4'd0, 4'd10, 64'h0, 4'd0, 64'd5);
        issue(4'd1, 4'd10, 64'h0, 4'd10, 64'h0);
        bcast(4'd11, 64'h99);
        check(disp_valid == 1'b0, "R10", "unrelated broadcast wakes nothing",
              64'(disp_valid), 64'd0);
        bcast(4'd10, 64'd40);
        check(disp_valid && disp_tag == 4'd1, "R7", "lowest ready entry first",
              64'(disp_tag), 64'd1);
        check(disp_opa == 64'd40, "R5", "first waiter captured", disp_opa, 64'd40);
        step();
        check(disp_valid && disp_tag == 4'd2, "R7", "second entry next cycle",
              64'(disp_tag), 64'd2);
        check(disp_opa == 64'd40 && disp_opb == 64'd40, "R5", "both sources of second waiter",
              disp_opb, 64'd40);
        wait_result(4'd1, 64'd45, "R5");
        wait_result(4'd2, 64'd0, "R5");
        step();

        // R9: fill the pool, offer an issue that must be dropped
        issue(4'd0, 4'd12, 64'h0, 4'd0, 64'd1);
        issue(4'd1, 4'd12, 64'h0, 4'd0, 64'd2);
        issue(4'd3, 4'd12, 64'h0, 4'd0, 64'd3);
        check(iss_ready == 1'b0, "R9", "iss_ready low when full", 64'(iss_ready), 64'd0);
        issue(4'd0, 4'd0, 64'd100, 4'd0, 64'd200);
        check(disp_valid == 1'b0, "R9", "dropped issue not dispatched", 64'(disp_valid), 64'd0);
        bcast(4'd12, 64'd50);
        check(disp_valid && disp_tag == 4'd1, "R7", "order after shared wake",
              64'(disp_tag), 64'd1);
        check(iss_ready == 1'b0, "R8", "dispatched entry still allocated",
              64'(iss_ready), 64'd0);
        wait_result(4'd1, 64'd51, "R8");
        wait_result(4'd2, 64'd48, "R8");
        wait_result(4'd3, 64'd49, "R8");
        step();
        check(iss_ready == 1'b1, "R8", "entries freed after own broadcast",
              64'(iss_ready), 64'd1);
        begin
            int stray;
            stray = 0;
            for (int i = 0; i < 10; i++) begin
                if (cdb_valid || disp_valid) stray++;
                step();
            end
            check(stray == 0, "R9", "no activity from dropped issue", 64'(stray), 64'd0);
        end

        // R8, R2: freed entry 0 is reused
        issue(4'd0, 4'd0, 64'd7, 4'd0, 64'd8);
        check(disp_valid && disp_tag == 4'd1, "R8", "freed entry reused", 64'(disp_tag), 64'd1);
        wait_result(4'd1, 64'd15, "R8");
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule